// File: doc/BRIEF.md
# E1 Channel-Associated Signaling Transmit Inserter

This block places channel-associated signaling into timeslot 16 of an outgoing E1 bit stream. A host loads sixteen 8-bit signaling registers through a simple write port. At each multiframe start the block copies all sixteen into a private shift register. During the following multiframe it shifts that copy out, one byte per frame, in the signaling timeslot. Every other bit of the stream passes through from the serial input. Because of the copy, a host write never disturbs a multiframe that has already started.

The stream is clocked by a bit-enable strobe. One bit is accepted per strobe, and the output is registered on the same strobe. An external multiframe sync pulse, qualified by the strobe, marks the first bit of frame 0 and realigns the internal frame, timeslot and bit counters.

A status flag rises at every multiframe start. It tells the host that a fresh 2 ms window has opened for the next set of values. The host clears the flag by writing one to it.

Top module: `e1_cas_tx`

## Requirements
- R1: After reset, `ser_o` and `mf_flag_o` are 0 and all sixteen signaling registers hold 0.
- R2: A write to an address from 0x40 to 0x4F stores into signaling register (address − 0x40 + 1). A write to any other address leaves every signaling register unchanged.
- R3: Register 1 (address 0x40) always keeps its upper four bits at 0. Its lower four bits store what was written: bit 2 is the remote multiframe alarm and bits 0, 1 and 3 are spare.
- R4: While `cas_en_i` is 1, bit b (b = 0..7) of timeslot 16 in frame f (f = 0..15) is bit 7−b of the copy of register f+1 taken at the start of the current multiframe. Bits go out MSB first.
- R5: Every bit outside timeslot 16 is copied from `ser_i` to `ser_o`.
- R6: While `cas_en_i` is 0, the timeslot 16 bits are also copied from `ser_i`.
- R7: A register write made after a multiframe has started has no effect on that multiframe's timeslot 16 bits. It takes effect from the next multiframe.
- R8: A bit strobed with `mf_sync_i` = 1 is taken as frame 0, timeslot 0, bit 0. That bit starts a new multiframe and takes a new copy of the registers. Frame counting continues from that bit. `mf_sync_i` is ignored while `bit_en_i` is 0.
- R9: `mf_flag_o` becomes 1 on the strobe of the first bit of each multiframe. A write with data bit 0 = 1 to address 0x50 clears it. A write of 0 to that bit leaves it set.
- R10: `ser_o` changes only on a clock edge where `bit_en_i` is 1, and it then shows the result for the bit presented on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| host_wr_i | input | 1 | Host write strobe |
| host_addr_i | input | 8 | Host write address |
| host_wdata_i | input | 8 | Host write data |
| cas_en_i | input | 1 | Enables signaling insertion in timeslot 16 |
| bit_en_i | input | 1 | One-cycle strobe per stream bit |
| mf_sync_i | input | 1 | Marks first bit of a multiframe (qualified by bit_en_i) |
| ser_i | input | 1 | Upstream serial bit |
| ser_o | output | 1 | Outgoing serial bit, registered |
| mf_flag_o | output | 1 | Multiframe-start status flag, write-one-to-clear |

## Verification
A corrupted bit, timeslot or frame counter moves the signaling window in time. A bench that predicts every output bit sees the mismatch within one 256-bit frame at most. A wrong shift copy or a wrong register value shows in timeslot 16 of the affected frame, so it surfaces within one 4096-bit multiframe. A flag error shows on the strobe of the next multiframe start or right after a clearing write.

// File: rtl/e1_cas_pkg.sv
package e1_cas_pkg;
    localparam int unsigned BITS_PER_SLOT   = 8;
    localparam int unsigned SLOTS_PER_FRAME = 32;
    localparam int unsigned FRAMES_PER_MF   = 16;
    localparam int unsigned SIG_SLOT        = 16;
    localparam int unsigned HDR_KEEP_BITS   = 4;
    localparam int unsigned ADDR_W          = 8;
    localparam logic [7:0]  SIG_BASE_ADDR   = 8'h40;
    localparam logic [7:0]  FLAG_ADDR       = 8'h50;
endpackage

// File: rtl/e1_cas_timing.sv
module e1_cas_timing #(
    parameter int unsigned BYTE_W   = e1_cas_pkg::BITS_PER_SLOT,
    parameter int unsigned SLOTS    = e1_cas_pkg::SLOTS_PER_FRAME,
    parameter int unsigned FRAMES   = e1_cas_pkg::FRAMES_PER_MF,
    parameter int unsigned SIG_SLOT = e1_cas_pkg::SIG_SLOT
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic bit_en_i,
    input  logic mf_sync_i,
    output logic mf_start_o,
    output logic sig_bit_o
);
    localparam int unsigned BIT_W   = $clog2(BYTE_W);
    localparam int unsigned SLOT_W  = $clog2(SLOTS);
    localparam int unsigned FRAME_W = $clog2(FRAMES);

    typedef struct packed {
        logic [FRAME_W-1:0] frame;
        logic [SLOT_W-1:0]  slot;
        logic [BIT_W-1:0]   bitn;
    } pos_t;

    pos_t pos_q, pos_d, cur, nxt;

    always_comb begin
        cur = mf_sync_i ? '0 : pos_q;
        nxt = cur;
        if (cur.bitn == BIT_W'(BYTE_W - 1)) begin
            nxt.bitn = '0;
            if (cur.slot == SLOT_W'(SLOTS - 1)) begin
                nxt.slot = '0;
                if (cur.frame == FRAME_W'(FRAMES - 1)) nxt.frame = '0;
                else                                    nxt.frame = cur.frame + 1'b1;
            end else begin
                nxt.slot = cur.slot + 1'b1;
            end
        end else begin
            nxt.bitn = cur.bitn + 1'b1;
        end
        pos_d = bit_en_i ? nxt : pos_q;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) pos_q <= '0;
        else         pos_q <= pos_d;
    end

    assign mf_start_o = bit_en_i && (cur == '0);
    assign sig_bit_o  = bit_en_i && (cur.slot == SLOT_W'(SIG_SLOT));

    assert_sync_realign_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bit_en_i && mf_sync_i) |=> (pos_q.frame == '0 && pos_q.slot == '0 && pos_q.bitn == BIT_W'(1)));

    assert_pos_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !bit_en_i |=> $stable(pos_q));
endmodule

// File: rtl/e1_cas_regfile.sv
module e1_cas_regfile #(
    parameter int unsigned BYTE_W    = e1_cas_pkg::BITS_PER_SLOT,
    parameter int unsigned NREG      = e1_cas_pkg::FRAMES_PER_MF,
    parameter int unsigned ADDR_W    = e1_cas_pkg::ADDR_W,
    parameter int unsigned HDR_KEEP  = e1_cas_pkg::HDR_KEEP_BITS,
    parameter logic [ADDR_W-1:0] BASE = e1_cas_pkg::SIG_BASE_ADDR,
    parameter logic [ADDR_W-1:0] STAT = e1_cas_pkg::FLAG_ADDR,
    localparam int unsigned SH_W     = BYTE_W * NREG
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BYTE_W-1:0] wdata_i,
    input  logic              set_i,
    output logic [SH_W-1:0]   snap_o,
    output logic              flag_o
);
    localparam int unsigned IDX_W = $clog2(NREG);
    localparam logic [BYTE_W-1:0] HDR_MASK = BYTE_W'((1 << HDR_KEEP) - 1);

    typedef struct packed {
        logic [NREG-1:0][BYTE_W-1:0] regs;
        logic                        flag;
    } rf_t;

    rf_t q, d;
    logic [ADDR_W-1:0] off;
    logic              hit;
    logic [IDX_W-1:0]  idx;

    always_comb begin
        off = addr_i - BASE;
        hit = wr_i && (off < ADDR_W'(NREG));
        idx = off[IDX_W-1:0];
        d   = q;
        if (hit) begin
            if (idx == '0) d.regs[idx] = wdata_i & HDR_MASK;
            else           d.regs[idx] = wdata_i;
        end
        if (set_i)                                d.flag = 1'b1;
        else if (wr_i && addr_i == STAT && wdata_i[0]) d.flag = 1'b0;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    for (genvar k = 0; k < NREG; k++) begin : g_snap
        assign snap_o[SH_W-1-k*BYTE_W -: BYTE_W] = q.regs[k];
    end
    assign flag_o = q.flag;

    assert_hdr_mask_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && addr_i == BASE) |=> (q.regs[0] == ($past(wdata_i) & HDR_MASK)));

    assert_flag_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        set_i |=> flag_o);

    assert_flag_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && addr_i == STAT && wdata_i[0] && !set_i) |=> !flag_o);
endmodule

// File: rtl/e1_cas_shifter.sv
module e1_cas_shifter #(
    parameter int unsigned BYTE_W = e1_cas_pkg::BITS_PER_SLOT,
    parameter int unsigned FRAMES = e1_cas_pkg::FRAMES_PER_MF,
    localparam int unsigned SH_W  = BYTE_W * FRAMES
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            bit_en_i,
    input  logic            mf_start_i,
    input  logic            sig_bit_i,
    input  logic            cas_en_i,
    input  logic            ser_i,
    input  logic [SH_W-1:0] snap_i,
    output logic            ser_o
);
    typedef struct packed {
        logic [SH_W-1:0] sh;
        logic            ser;
    } sh_state_t;

    sh_state_t q, d;

    always_comb begin
        d = q;
        if (bit_en_i) d.ser = (sig_bit_i && cas_en_i) ? q.sh[SH_W-1] : ser_i;
        if (mf_start_i)     d.sh = snap_i;
        else if (sig_bit_i) d.sh = {q.sh[SH_W-2:0], 1'b0};
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign ser_o = q.ser;

    assert_ser_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !bit_en_i |=> $stable(ser_o));

    assert_passthru_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bit_en_i && !sig_bit_i) |=> (ser_o == $past(ser_i)));

    assert_snapshot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mf_start_i |=> (q.sh == $past(snap_i)));
endmodule

// File: rtl/e1_cas_tx.sv
module e1_cas_tx #(
    parameter int unsigned BYTE_W   = e1_cas_pkg::BITS_PER_SLOT,
    parameter int unsigned SLOTS    = e1_cas_pkg::SLOTS_PER_FRAME,
    parameter int unsigned FRAMES   = e1_cas_pkg::FRAMES_PER_MF,
    parameter int unsigned SIG_SLOT = e1_cas_pkg::SIG_SLOT,
    parameter int unsigned ADDR_W   = e1_cas_pkg::ADDR_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              host_wr_i,
    input  logic [ADDR_W-1:0] host_addr_i,
    input  logic [BYTE_W-1:0] host_wdata_i,
    input  logic              cas_en_i,
    input  logic              bit_en_i,
    input  logic              mf_sync_i,
    input  logic              ser_i,
    output logic              ser_o,
    output logic              mf_flag_o
);
    localparam int unsigned SH_W = BYTE_W * FRAMES;

    logic            mf_start;
    logic            sig_bit;
    logic [SH_W-1:0] snap;

    e1_cas_timing #(
        .BYTE_W(BYTE_W), .SLOTS(SLOTS), .FRAMES(FRAMES), .SIG_SLOT(SIG_SLOT)
    ) u_timing (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .bit_en_i   (bit_en_i),
        .mf_sync_i  (mf_sync_i),
        .mf_start_o (mf_start),
        .sig_bit_o  (sig_bit)
    );

    e1_cas_regfile #(
        .BYTE_W(BYTE_W), .NREG(FRAMES), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_i    (host_wr_i),
        .addr_i  (host_addr_i),
        .wdata_i (host_wdata_i),
        .set_i   (mf_start),
        .snap_o  (snap),
        .flag_o  (mf_flag_o)
    );

    e1_cas_shifter #(
        .BYTE_W(BYTE_W), .FRAMES(FRAMES)
    ) u_shift (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .bit_en_i   (bit_en_i),
        .mf_start_i (mf_start),
        .sig_bit_i  (sig_bit),
        .cas_en_i   (cas_en_i),
        .ser_i      (ser_i),
        .snap_i     (snap),
        .ser_o      (ser_o)
    );
endmodule

// File: tb/e1_cas_tx_tb.sv
module e1_cas_tx_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0;
    logic [7:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic       cas_en = 1'b0;
    logic       bit_en = 1'b0;
    logic       mf_sync = 1'b0;
    logic       ser_in = 1'b0;
    logic       ser_out;
    logic       mf_flag;

    always #5 clk = ~clk;

    e1_cas_tx u_dut (
        .clk_i(clk), .rst_ni(rst_n), .host_wr_i(host_wr), .host_addr_i(host_addr),
        .host_wdata_i(host_wdata), .cas_en_i(cas_en), .bit_en_i(bit_en),
        .mf_sync_i(mf_sync), .ser_i(ser_in), .ser_o(ser_out), .mf_flag_o(mf_flag)
    );

    int         checks = 0;
    int         errors = 0;
    logic [7:0] m_regs [16];
    logic [7:0] m_snap [16];
    logic [15:0] m_dirty;
    int         m_pos = 0;
    logic       m_flag = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    bit         done = 1'b0;

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [7:0] a, input logic [7:0] v);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = v;
        @(negedge clk);
        host_wr = 1'b0;
        if (a >= 8'h40 && a <= 8'h4F) begin
            m_regs[a - 8'h40] = (a == 8'h40) ? (v & 8'h0F) : v;
            m_dirty[a - 8'h40] = 1'b1;
        end
        if (a == 8'h50 && v[0]) m_flag = 1'b0;
        chk(mf_flag == m_flag, "R9", mf_flag, m_flag);
    endtask

    task automatic send_bit(input logic sync);
        int pos, frame, slot, b;
        logic din, expv, prev;
        string req;
        @(negedge clk);
        din = lfsr[0];
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        bit_en = 1'b1; mf_sync = sync; ser_in = din;
        pos = sync ? 0 : m_pos;
        if (pos == 0) begin
            for (int k = 0; k < 16; k++) m_snap[k] = m_regs[k];
            m_dirty = '0;
            m_flag = 1'b1;
        end
        frame = pos / 256;
        slot  = (pos / 8) % 32;
        b     = pos % 8;
        if (slot == 16 && cas_en) begin
            expv = m_snap[frame][7-b];
            if (frame == 0)            req = "R3";
            else if (m_dirty[frame])   req = "R7";
            else                       req = "R2/R4";
        end else if (slot == 16) begin
            expv = din; req = "R6";
        end else begin
            expv = din; req = "R5";
        end
        m_pos = (pos + 1) % 4096;
        @(negedge clk);
        chk(ser_out == expv, req, ser_out, expv);
        chk(mf_flag == m_flag, "R9", mf_flag, m_flag);
        bit_en = 1'b0; mf_sync = sync; ser_in = ~din;
        prev = ser_out;
        @(negedge clk);
        mf_sync = 1'b0;
        chk(ser_out == prev, "R10", ser_out, prev);
    endtask

    task automatic run_bits(input int n);
        for (int i = 0; i < n; i++) send_bit(1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 16; k++) begin m_regs[k] = '0; m_snap[k] = '0; end
        m_dirty = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ser_out == 1'b0, "R1", ser_out, 0);
        chk(mf_flag == 1'b0, "R1", mf_flag, 0);

        // Multiframe with cleared registers: R1 zeros in timeslot 16
        cas_en = 1'b1;
        send_bit(1'b1);
        run_bits(4095);

        // Load registers; header mask R3, ignored addresses R2
        for (int k = 0; k < 16; k++) host_write(8'h40 + 8'(k), 8'hA5 ^ 8'(k * 17));
        host_write(8'h3F, 8'hFF);
        host_write(8'h51, 8'hFF);
        host_write(8'hC4, 8'h3C);
        host_write(8'h50, 8'h00);   // R9: bit 0 clear, flag stays
        host_write(8'h50, 8'h01);   // R9: clear
        run_bits(5 * 256);
        // R7: mid-multiframe write must not alter current multiframe
        host_write(8'h43, 8'h5A);
        host_write(8'h4F, 8'h81);
        run_bits(4096 - 5 * 256);
        run_bits(4096);

        // R6: insertion disabled
        cas_en = 1'b0;
        run_bits(4096);

        // R8: realign in mid multiframe
        cas_en = 1'b1;
        host_write(8'h40, 8'hFF);
        run_bits(1000);
        send_bit(1'b1);
        run_bits(4095 + 300);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule